// File: doc/BRIEF.md
# Tile Background Pixel Shifter

This block is the background pixel stage of a tile-based video generator. Each bit plane has a 16-bit register that holds the pattern bits of two neighbouring tiles. On every enabled pixel clock, a 3-bit fine horizontal scroll value selects one bit position from each plane register. The two selected bits form a 2-bit pixel index, which is registered onto the output. Both registers then move one place toward their most significant end.

The tile fetch logic drives a load strobe on every eighth enabled pixel clock. On that clock the next tile's two pattern bytes enter the low halves of the registers. The shift happens in the same cycle, so the high halves keep the bits that were just moved up. In a pattern byte, bit 7 is the leftmost pixel. The registers shift toward the high end without reversing the byte, so the leftmost pixel reaches the tap first.

Raising fine scroll moves the tap toward the low end of the register. The visible picture then moves left by that many pixels, and this works across tile boundaries.

Top module: `tile_bg_shifter`

## Requirements
- R1: While `rst_n` is low at a clock edge, both plane registers and the `pixel` output are cleared to zero.
- R2: On an enabled cycle with `load` high, the plane register's bits [15:8] take its old bits [14:7]. Bits [7:0] take the new pattern byte: `pat_lo` for plane 0 and `pat_hi` for plane 1.
- R3: On an enabled cycle with `load` low, each plane register shifts left by one place and a zero enters bit 0.
- R4: The tapped bit of each plane is bit (15 − `fine_x`) of its register, read before the cycle's shift. `pixel[1]` comes from plane 1 and `pixel[0]` from plane 0.
- R5: Bit 7 of a pattern byte is tile pixel 0 and bit 0 is tile pixel 7. Let tiles be loaded on enabled cycles 0, 8, 16, … after reset. Then the pixel shown after enabled cycle c is stream pixel c − 9 + `fine_x`. Stream pixels before index 0 read as zero.
- R6: `pixel` is registered. It shows the tap taken on the most recent enabled cycle, one clock after that cycle.
- R7: While `pix_en` is low, both registers and `pixel` hold their values, and `load`, the pattern bytes and `fine_x` are ignored.
- R8: A change of `fine_x` affects the pixel captured on the next enabled cycle, with no other delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_en | input | 1 | Pixel clock enable; when low, all state holds |
| load | input | 1 | Tile boundary strobe; loads the new pattern bytes into the low halves |
| pat_lo | input | 8 | Pattern byte for plane 0, bit 7 leftmost |
| pat_hi | input | 8 | Pattern byte for plane 1, bit 7 leftmost |
| fine_x | input | 3 | Fine horizontal scroll; selects the tap position |
| pixel | output | 2 | Registered 2-bit background pixel index |

## Verification
The assertions assume that `rst_n` is driven low at time zero. They also assume that `load` only matters together with `pix_en`, so they check register motion only on enabled cycles. They do not require the eight-cycle load spacing. The pixel sequence of R5 does depend on that spacing. The bench therefore asserts `load` only on enabled cycles whose count is a multiple of eight, and while `pix_en` is low it drives `load` and random bytes only to show that they are ignored.

// File: rtl/tile_shift_pkg.sv
// Package: shared sizes for the tile background shifter.
// Assumes two bit planes and a power-of-two tile width.
package tile_shift_pkg;
    parameter int TILE_W  = 8;
    parameter int PLANES  = 2;
    localparam int SR_W   = 2 * TILE_W;
    localparam int FX_W   = $clog2(TILE_W);
    typedef logic [TILE_W-1:0] pat_byte_t;
    typedef logic [SR_W-1:0]   plane_sr_t;
    typedef logic [PLANES-1:0] pix_idx_t;
endpackage

// File: rtl/tile_plane_shreg.sv
// Module: one bit plane's two-tile shift register.
// Shifts left once per enabled cycle. A load in the same cycle puts the new
// byte into the low half while the high half keeps the bits just shifted up.
// Assumes the byte has bit 7 as its leftmost pixel, so no reversal is needed.
module tile_plane_shreg
    import tile_shift_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pix_en,
    input  logic      load,
    input  pat_byte_t pat,
    output plane_sr_t sr
);
    // Register update: clear, hold, shift, or shift-and-reload.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sr <= '0;
        else if (pix_en) begin
            if (load)
                sr <= {sr[SR_W-2:TILE_W-1], pat};
            else
                sr <= {sr[SR_W-2:0], 1'b0};
        end
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> sr == '0);
    assert_load_halves_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_en && load) |=> (sr[TILE_W-1:0] == $past(pat)) &&
                             (sr[SR_W-1:TILE_W] == $past(sr[SR_W-2:TILE_W-1])));
    assert_shift_left_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_en && !load) |=> (sr[SR_W-1:1] == $past(sr[SR_W-2:0])) && !sr[0]);
    assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_en |=> $stable(sr));
endmodule

// File: rtl/tile_tap_sel.sv
// Module: scroll tap selector.
// Picks bit (SR_W-1-fine_x) from each plane register, which is purely
// combinational. Assumes the planes are given in pixel-index bit order.
module tile_tap_sel
    import tile_shift_pkg::*;
(
    input  plane_sr_t       planes [PLANES],
    input  logic [FX_W-1:0] fine_x,
    output pix_idx_t        tap
);
    localparam int TOP = SR_W - 1;
    logic [FX_W:0] pos;
    // Tap position: counted down from the top bit by the scroll amount.
    always_comb pos = (FX_W+1)'(TOP) - {1'b0, fine_x};

    for (genvar p = 0; p < PLANES; p++) begin : g_tap
        logic [FX_W:0] pos_ok;
        // Per-plane bit pick at the scroll position.
        always_comb begin
            pos_ok = pos;
            tap[p] = planes[p][pos_ok];
        end
    end
endmodule

// File: rtl/tile_bg_shifter.sv
// Module: background pixel shifter, the top level.
// Two plane registers feed a scroll tap, and the tap is registered as the
// 2-bit pixel. Assumes the tile fetch logic raises load with pix_en on every
// eighth enabled cycle.
module tile_bg_shifter
    import tile_shift_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pix_en,
    input  logic            load,
    input  logic [7:0]      pat_lo,
    input  logic [7:0]      pat_hi,
    input  logic [2:0]      fine_x,
    output logic [1:0]      pixel
);
    pat_byte_t pats   [PLANES];
    plane_sr_t planes [PLANES];
    pix_idx_t  tap;

    // Byte routing: plane 0 takes the low pattern, plane 1 the high pattern.
    always_comb begin
        pats[0] = pat_lo;
        pats[1] = pat_hi;
    end

    for (genvar p = 0; p < PLANES; p++) begin : g_plane
        tile_plane_shreg u_sr (
            .clk    (clk),
            .rst_n  (rst_n),
            .pix_en (pix_en),
            .load   (load),
            .pat    (pats[p]),
            .sr     (planes[p])
        );
    end

    tile_tap_sel u_tap (
        .planes (planes),
        .fine_x (fine_x),
        .tap    (tap)
    );

    // Output stage: capture the tap on each enabled cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pixel <= '0;
        else if (pix_en)
            pixel <= tap;
    end

    assert_pixel_reset_R1: assert property (@(posedge clk)
        !rst_n |=> pixel == 2'b00);
    assert_pixel_tap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pix_en |=> pixel == {$past(planes[1][15 - fine_x]), $past(planes[0][15 - fine_x])});
    assert_pixel_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_en |=> $stable(pixel));
endmodule

// File: tb/tile_bg_shifter_test.sv
module tile_bg_shifter_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pix_en = 1'b0;
    logic       load = 1'b0;
    logic [7:0] pat_lo = '0;
    logic [7:0] pat_hi = '0;
    logic [2:0] fine_x = '0;
    logic [1:0] pixel;

    int checks = 0;
    int failures = 0;
    logic [7:0] t_lo [8];
    logic [7:0] t_hi [8];

    tile_bg_shifter uut (
        .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .load(load),
        .pat_lo(pat_lo), .pat_hi(pat_hi), .fine_x(fine_x), .pixel(pixel)
    );

    always #4 clk = ~clk;

    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Stream pixel g: tile g/8, bit 7 leftmost; negative indices are zero.
    function automatic logic [1:0] stream_px(input int g);
        int t, b;
        if (g < 0) return 2'b00;
        t = g / 8;
        b = 7 - (g % 8);
        return {t_hi[t][b], t_lo[t][b]};
    endfunction

    // Drives one cycle from a negedge and returns at the following negedge.
    task automatic step(input logic en, input logic ld, input logic [7:0] lo,
                        input logic [7:0] hi, input logic [2:0] fx);
        pix_en = en; load = ld; pat_lo = lo; pat_hi = hi; fine_x = fx;
        @(posedge clk);
        @(negedge clk);
    endtask

    // Enabled cycle c of a stream: loads tile c/8 on boundaries.
    task automatic stream_cycle(input int c, input logic [2:0] fx);
        if (c % 8 == 0) step(1'b1, 1'b1, t_lo[c/8], t_hi[c/8], fx);
        else            step(1'b1, 1'b0, 8'h5A, 8'hC3, fx);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step(1'b1, 1'b1, 8'hFF, 8'hFF, 3'd0);
        step(1'b1, 1'b1, 8'hFF, 8'hFF, 3'd7);
        check("R1 reset clears pixel", pixel, 2'b00);
        rst_n = 1'b1;
    endtask

    // R4 R5 R6: fixed scroll, pixel after enabled cycle c is stream(c-9+f).
    task automatic test_fixed_scroll(input logic [2:0] f);
        do_reset();
        for (int c = 0; c < 56; c++) begin
            stream_cycle(c, f);
            check($sformatf("R5 fine_x=%0d c=%0d", f, c), pixel, stream_px(c - 9 + int'(f)));
        end
    endtask

    // R8: scroll changes each cycle and takes effect on that cycle.
    task automatic test_scroll_change();
        do_reset();
        for (int c = 0; c < 56; c++) begin
            logic [2:0] f = 3'((c * 5 + c / 3) % 8);
            stream_cycle(c, f);
            check($sformatf("R8 varying scroll c=%0d", c), pixel, stream_px(c - 9 + int'(f)));
        end
    endtask

    // R7: disabled cycles with load, bytes and scroll toggling change nothing.
    task automatic test_stall();
        logic [1:0] held;
        do_reset();
        for (int c = 0; c < 56; c++) begin
            if (c == 16 || c == 21 || c == 24) begin
                held = pixel;
                for (int s = 0; s < 5; s++) begin
                    step(1'b0, 1'b1, 8'($urandom), 8'($urandom), 3'(s));
                    check("R7 pixel holds while disabled", pixel, held);
                end
            end
            stream_cycle(c, 3'd2);
            check($sformatf("R7 stream intact c=%0d", c), pixel, stream_px(c - 7));
        end
    endtask

    // R1: reset mid-stream clears the registers, so the next stream starts from zeros.
    task automatic test_mid_reset();
        for (int c = 0; c < 12; c++) stream_cycle(c, 3'd7);
        do_reset();
        for (int c = 0; c < 2; c++) begin
            stream_cycle(c, 3'd7);
            check($sformatf("R1 cleared history c=%0d", c), pixel, stream_px(c - 2));
        end
    endtask

    initial begin
        for (int k = 0; k < 8; k++) begin
            t_lo[k] = 8'(8'hA5 ^ (k * 37));
            t_hi[k] = 8'(8'h3C + k * 71);
        end
        t_lo[1] = 8'h80; t_hi[1] = 8'h01;
        @(negedge clk);
        do_reset();
        for (int f = 0; f < 8; f++) test_fixed_scroll(3'(f));
        test_scroll_change();
        test_stall();
        test_mid_reset();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule